// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Plane

This block is the core of a small programmable logic device. A programmable AND plane feeds a fixed OR plane. The sixteen input signals each produce a true line and an inverted line, so the AND plane sees thirty-two lines. There are sixty-four product terms. A configuration store holds one bit for each crossing of a line and a term. A set bit means the line takes part in that term's AND. An open bit means the term ignores that line.

The product terms fall into eight groups of eight. In each group, the first seven terms always feed that group's OR sum. The eighth term is the spare term of the group's output cell. A per-group select input decides whether the spare term also joins the sum. The block presents all sixty-four term values and the eight sums to the downstream output cells.

Programming starts with a bulk erase. The erase opens every crossing in one clock cycle. Individual crossings are then set one per cycle through an addressed write port. A write can only set a bit; only an erase clears one. An unused term is made harmless by connecting both polarities of some input to it, which forces it FALSE.

Top module: `pterm_array`

## Requirements
- R1: While reset is asserted, and after it is released, every crossing is open. All 64 terms then read 1, and every sum reads 1.
- R2: Array line 2*i carries input `in_sig[i]`. Array line 2*i+1 carries its complement. This holds for i from 0 to 15.
- R3: Term t is the AND of every array line whose crossing bit (t, line) is set.
- R4: A term with no crossing set reads 1 for every input value.
- R5: A term that has both line 2*i and line 2*i+1 set reads 0 for every input value.
- R6: A write with `wr_en` high and `erase` low sets exactly crossing (`wr_term`, `wr_line`). The new bit is in effect from the cycle after the clock edge. Repeating a write does not change the array, and no write clears a bit.
- R7: An `erase` pulse opens every crossing at the next clock edge. A write presented in the same cycle as the erase is ignored.
- R8: Group g, for g from 0 to 7, owns terms 8*g to 8*g+7. Terms 8*g to 8*g+6 are its seven sum terms. Term 8*g+7 is its spare term.
- R9: `sum[g]` is the OR of the group's seven sum terms. When `sel8[g]` is 0 the spare term is left out. When `sel8[g]` is 1 the spare term is ORed in as well.
- R10: Term values and sums follow `in_sig` and `sel8` combinationally, within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration store |
| rst_n | input | 1 | Active-low asynchronous reset; opens all crossings |
| in_sig | input | 16 | Logic inputs (dedicated inputs and feedback) |
| wr_en | input | 1 | Write strobe for one crossing bit |
| wr_term | input | 6 | Term index of the write |
| wr_line | input | 5 | Array line index of the write |
| erase | input | 1 | Bulk erase; opens all crossings at the next edge |
| sel8 | input | 8 | Per group: 1 adds the spare term to the sum |
| pterm | output | 64 | Product term values |
| sum | output | 8 | Per-group OR sums |

## Verification
The hardest case to reach is a single crossing seen in isolation. The array normally sits at all-open, where every sum is saturated at 1, so one stray bit does not show at the sums. The bench therefore erases before each single-line probe and checks all sixty-four terms, not only the sums. For the sum selection, the stimulus first kills the seven sum terms of every group with conflicting crossings. It then leaves either one sum term or only the spare term open, so each sum bit depends on exactly one term and on `sel8`. It also drives an erase and a write in the same cycle, and repeats writes to a bit that is already set.

// File: rtl/pterm_array.sv
module pterm_array #(
  parameter int N_IN   = 16,
  parameter int N_GRP  = 8,
  parameter int GRP_SZ = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [N_IN-1:0]                   in_sig,
  input  logic                              wr_en,
  input  logic [$clog2(N_GRP*GRP_SZ)-1:0]   wr_term,
  input  logic [$clog2(2*N_IN)-1:0]         wr_line,
  input  logic                              erase,
  input  logic [N_GRP-1:0]                  sel8,
  output logic [N_GRP*GRP_SZ-1:0]           pterm,
  output logic [N_GRP-1:0]                  sum
);
  localparam int N_LINE = 2 * N_IN;
  localparam int N_TERM = N_GRP * GRP_SZ;

  logic [N_TERM-1:0][N_LINE-1:0] cfg;
  logic [N_LINE-1:0]             lines;

  for (genvar i = 0; i < N_IN; i++) begin : g_line
    assign lines[2*i]   = in_sig[i];
    assign lines[2*i+1] = ~in_sig[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cfg <= '0;
    else if (erase)
      cfg <= '0;
    else if (wr_en)
      cfg[wr_term][wr_line] <= 1'b1;
  end

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    assign pterm[t] = &(lines | ~cfg[t]);
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_sum
    assign sum[g] = (|pterm[g*GRP_SZ +: GRP_SZ-1]) | (sel8[g] & pterm[g*GRP_SZ+GRP_SZ-1]);
  end

  function automatic logic has_pair(input logic [N_LINE-1:0] row);
    logic r;
    r = 1'b0;
    for (int i = 0; i < N_IN; i++)
      if (row[2*i] && row[2*i+1]) r = 1'b1;
    return r;
  endfunction

  // R7
  erase_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase |=> (&pterm));

  // R6
  write_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !erase) |=> cfg[$past(wr_term)][$past(wr_line)]);

  // R6
  no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !erase |=> (($past(cfg) & ~cfg) == '0));

  for (genvar t = 0; t < N_TERM; t++) begin : g_conf_chk
    // R5
    conflict_false_chk: assert property (@(posedge clk) disable iff (!rst_n)
      has_pair(cfg[t]) |-> !pterm[t]);
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_sum_chk
    // R9
    spare_excluded_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel8[g] && pterm[g*GRP_SZ +: GRP_SZ-1] == '0) |-> !sum[g]);
  end
endmodule

// File: tb/pterm_array_bench.sv
module pterm_array_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] in_sig = '0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_term = '0;
  logic [4:0]  wr_line = '0;
  logic        erase = 1'b0;
  logic [7:0]  sel8 = '0;
  logic [63:0] pterm;
  logic [7:0]  sum;

  int compared = 0;
  int mismatched = 0;
  logic [31:0] mcfg [64];

  always #5 clk = ~clk;

  pterm_array u_pterm_array (
    .clk(clk), .rst_n(rst_n), .in_sig(in_sig), .wr_en(wr_en),
    .wr_term(wr_term), .wr_line(wr_line), .erase(erase),
    .sel8(sel8), .pterm(pterm), .sum(sum)
  );

  function automatic logic [63:0] exp_terms();
    logic [63:0] r;
    for (int t = 0; t < 64; t++) begin
      r[t] = 1'b1;
      for (int l = 0; l < 32; l++) begin
        logic lv;
        lv = (l % 2 == 0) ? in_sig[l/2] : ~in_sig[l/2];
        if (mcfg[t][l] && !lv) r[t] = 1'b0;
      end
    end
    return r;
  endfunction

  function automatic logic [7:0] exp_sums(input logic [63:0] tv);
    logic [7:0] r;
    for (int g = 0; g < 8; g++) begin
      r[g] = 1'b0;
      for (int k = 0; k < 7; k++) if (tv[g*8+k]) r[g] = 1'b1;
      if (sel8[g] && tv[g*8+7]) r[g] = 1'b1;
    end
    return r;
  endfunction

  task automatic chk(input string tag);
    logic [63:0] et;
    logic [7:0]  es;
    et = exp_terms();
    es = exp_sums(et);
    compared++;
    if (pterm !== et || sum !== es) begin
      mismatched++;
      $display("FAIL %s: pterm=%h exp=%h sum=%h exp=%h", tag, pterm, et, sum, es);
    end
  endtask

  task automatic wr(input int t, input int l);
    @(negedge clk);
    wr_en = 1'b1; wr_term = 6'(t); wr_line = 5'(l);
    @(negedge clk);
    wr_en = 1'b0;
    mcfg[t][l] = 1'b1;
  endtask

  task automatic do_erase();
    @(negedge clk);
    erase = 1'b1;
    @(negedge clk);
    erase = 1'b0;
    for (int t = 0; t < 64; t++) mcfg[t] = '0;
  endtask

  task automatic kill(input int t);
    wr(t, 0);
    wr(t, 1);
  endtask

  initial begin
    #2_000_000;
    mismatched++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int t = 0; t < 64; t++) mcfg[t] = '0;
    #1;
    in_sig = 16'h5a3c;
    sel8 = 8'h0f;
    #1 chk("R1 during reset");
    #20 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset");
    in_sig = 16'hffff;
    #1 chk("R4 all open, inputs high");

    // R2 R3: one line per probe, both input values
    for (int l = 0; l < 32; l++) begin
      do_erase();
      wr(l * 2 % 64, l);
      in_sig = 16'h0000;
      #1 chk("R2 R3 line probe low");
      in_sig = 16'h0000 | (16'h1 << (l / 2));
      #1 chk("R2 R3 line probe high");
    end

    // R3: multi-line AND swept over the inputs involved
    do_erase();
    wr(20, 0); wr(20, 3); wr(20, 10); wr(20, 31);
    for (int v = 0; v < 16; v++) begin
      in_sig = '0;
      in_sig[0] = v[0]; in_sig[1] = v[1]; in_sig[5] = v[2]; in_sig[15] = v[3];
      #1 chk("R3 four-line AND");
    end

    // R5: conflict pairs forced low
    do_erase();
    for (int i = 0; i < 16; i++) begin
      wr(i + 30, 2*i);
      wr(i + 30, 2*i + 1);
    end
    for (int v = 0; v < 8; v++) begin
      in_sig = 16'(v * 16'h2493);
      #1 chk("R5 conflict term");
    end

    // R6: repeated write leaves array unchanged
    do_erase();
    wr(7, 12);
    wr(7, 12);
    wr(7, 12);
    in_sig = 16'h0040;
    #1 chk("R6 repeated write, input high");
    in_sig = 16'h0000;
    #1 chk("R6 repeated write, input low");

    // R7: erase with a simultaneous write
    wr(3, 4);
    @(negedge clk);
    erase = 1'b1; wr_en = 1'b1; wr_term = 6'd50; wr_line = 5'd9;
    @(negedge clk);
    erase = 1'b0; wr_en = 1'b0;
    for (int t = 0; t < 64; t++) mcfg[t] = '0;
    in_sig = 16'h0000;
    #1 chk("R7 erase drops same-cycle write");
    in_sig = 16'h0010;
    #1 chk("R7 erase drops same-cycle write, input flipped");

    // R8 R9: all sum terms dead, spare open
    do_erase();
    for (int g = 0; g < 8; g++)
      for (int k = 0; k < 7; k++) kill(g*8 + k);
    for (int s = 0; s < 256; s++) begin
      sel8 = 8'(s);
      #1 chk("R9 spare select sweep");
    end
    // R8: revive one sum term per group
    for (int k = 0; k < 7; k++) begin
      do_erase();
      for (int g = 0; g < 8; g++) begin
        for (int j = 0; j < 8; j++) if (j != k) kill(g*8 + j);
      end
      sel8 = 8'h00;
      #1 chk("R8 single sum term, spare out");
      sel8 = 8'hff;
      #1 chk("R8 single sum term, spare in");
    end

    // R10: outputs follow inputs within a cycle
    do_erase();
    wr(63, 30);
    sel8 = 8'h80;
    for (int i = 0; i < 4; i++) begin
      in_sig = (i % 2 == 0) ? 16'h8000 : 16'h0000;
      #1 chk("R10 combinational follow");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule